// File: doc/BRIEF.md
# Scanline Display Capture Engine

This block copies one display line of 15-bit colour pixels into banked video memory, one pixel per clock. On a line-start strobe it checks whether this line is to be captured. If so, it takes a snapshot of the capture settings and the bank mapping status, then steps through the pixels of the line. For each pixel it issues a read to video memory (source B) and a request for the matching pixel of the front-end stream (source A: the composited screen or the 3D layer). It then writes a word to the destination bank. That word is source A, source B, or a weighted mix of the two.

A display controller drives the settings ports, pulses `line_start` with the line number at every line, and serves the read port with one cycle of latency. The mapping inputs tell the block which banks are currently open for direct display-side (LCD) access. The capture is dropped or its source reads are zeroed when a bank is not mapped that way. A second pulse marks the final visible line, so that the controller can end the capture sequence.

Top module: `scanline_capture`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `wr_en`, `line_done`, `pix_req` and `seq_done` are low.
- R2: A line is captured only when `line_start` arrives with `cfg_enable` high and `line_num` below `cfg_height`. Otherwise the block makes no request, no write and no `line_done`.
- R3: A captured line makes exactly 256 writes, or 128 writes when `cfg_narrow` is 1. The writes come on consecutive cycles, in pixel order 0 upward.
- R4: The write address for pixel i is `cfg_wr_ofs`·0x8000 + line·S + 2·i, taken modulo 2^18. S is 256 when the line is narrow and 512 otherwise. `wr_bank` equals `cfg_wr_bank`.
- R5: The read for pixel i goes to bank `cfg_rd_bank` at address `cfg_rd_ofs`·0x8000 + line·512 + 2·i, modulo 2^18. The read port, `scr_pix` and `td_pix` are all sampled one cycle after the request for that pixel.
- R6: With `cfg_src`=00 the word written is source A unchanged, including bit 15. Source A is `scr_pix` when `cfg_a_3d`=0 and `td_pix` when `cfg_a_3d`=1.
- R7: With `cfg_src`=01 the word written is the source B word unchanged.
- R8: With `cfg_src[1]`=1, each channel is (A·ea + B·eb)>>4, saturated at 31. The channels are red in bits 4:0, green in bits 9:5 and blue in bits 14:10. The weights ea and eb are `cfg_eva` and `cfg_evb` limited to 16. Bit 15 of the written word is 0.
- R9: In a mix, the A term counts only when ea is nonzero and A is opaque. The composited screen is always opaque; a 3D pixel is opaque when its bit 15 is 1. The B term counts whatever B's bit 15 is.
- R10: When `bank_lcd[cfg_wr_bank]` is 0 at line start, the line makes no writes, but `line_done` still pulses.
- R11: When `bank_lcd[cfg_rd_bank]` is 0 at line start, every source B word of that line is taken as 0.
- R12: Settings and mapping are sampled at line start. Changes to them, and further `line_start` pulses, have no effect until the line has finished.
- R13: `seq_done` pulses for one cycle, one cycle after `line_start` with `line_num`=191 while `cfg_enable` is 1.
- R14: `line_done` pulses for one cycle, in the same cycle as the last write of a captured line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Capture enable |
| cfg_src | input | 2 | 00 source A, 01 source B, 1x mix |
| cfg_a_3d | input | 1 | Source A is the 3D layer (1) or the screen (0) |
| cfg_narrow | input | 1 | 128-pixel line when 1, else 256 |
| cfg_height | input | 8 | Lines below this number are captured |
| cfg_eva | input | 5 | Weight of source A |
| cfg_evb | input | 5 | Weight of source B |
| cfg_wr_bank | input | 2 | Destination bank |
| cfg_wr_ofs | input | 2 | Destination offset in 0x8000 steps |
| cfg_rd_bank | input | 2 | Source B bank |
| cfg_rd_ofs | input | 2 | Source B offset in 0x8000 steps |
| bank_lcd | input | 4 | Per-bank flag: mapped for LCD access |
| line_start | input | 1 | Line-start strobe |
| line_num | input | 8 | Number of the starting line |
| scr_pix | input | 16 | Composited screen pixel |
| td_pix | input | 16 | 3D layer pixel |
| pix_req | output | 1 | Pixel and read request |
| pix_idx | output | 8 | Index of the requested pixel |
| rd_bank | output | 2 | Read bank |
| rd_addr | output | 18 | Read byte address |
| rd_data | input | 16 | Read word, one cycle after request |
| wr_en | output | 1 | Write strobe |
| wr_bank | output | 2 | Write bank |
| wr_addr | output | 18 | Write byte address |
| wr_data | output | 16 | Write word |
| line_done | output | 1 | Line capture finished |
| seq_done | output | 1 | Final capture line reached |

## Verification
The hardest case to reach is a line whose settings or mapping change while it is being captured. The line must keep the state it sampled at its start, even when another `line_start` arrives during the run. The stimulus starts a wide mixing line, then waits twenty cycles. It then rewrites the mode, weights, width, offset and mapping, and pulses `line_start` again. The scoreboard keeps the expectations computed from the original settings. Other hard cases are the mix corners, where a weight is above 16 or the A term is gated by a transparent 3D pixel. They are reached by pairing pixel patterns that are a function of the index, so both states of bit 15 occur within one line.

// File: rtl/capture_pkg.sv
package capture_pkg;

    localparam int DEF_LINE_W    = 8;
    localparam int DEF_ADDR_W    = 18;
    localparam int DEF_BANK_W    = 2;
    localparam int DEF_OFS_W     = 2;
    localparam int DEF_EV_W      = 5;
    localparam int DEF_WIDE_PIX  = 256;
    localparam int DEF_NARROW_PIX = 128;
    localparam int DEF_LAST_LINE = 191;
    localparam int OFS_SHIFT     = 15;
    localparam int EV_LIMIT      = 16;
    localparam int CH_MAX        = 31;

    typedef struct packed {
        logic       opaque;
        logic [4:0] blue;
        logic [4:0] green;
        logic [4:0] red;
    } pixel_t;

    typedef enum logic [1:0] {
        SRC_A    = 2'b00,
        SRC_B    = 2'b01,
        SRC_MIX  = 2'b10,
        SRC_MIXB = 2'b11
    } src_sel_e;

    function automatic logic [4:0] ev_limit(input logic [4:0] ev);
        return (ev > 5'(EV_LIMIT)) ? 5'(EV_LIMIT) : ev;
    endfunction

    function automatic logic [4:0] mix_chan(input logic [4:0] a, input logic [4:0] b,
                                            input logic [4:0] ea, input logic [4:0] eb,
                                            input logic use_a);
        logic [10:0] sum;
        logic [6:0]  sh;
        sum = (use_a ? 11'(a) * 11'(ea) : 11'd0) + 11'(b) * 11'(eb);
        sh  = sum[10:4];
        return (sh > 7'(CH_MAX)) ? 5'(CH_MAX) : sh[4:0];
    endfunction

endpackage

// File: rtl/cap_sequencer.sv
module cap_sequencer #(
    parameter int IDX_W      = 8,
    parameter int WIDE_PIX   = 256,
    parameter int NARROW_PIX = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             narrow,
    output logic             req,
    output logic [IDX_W-1:0] idx,
    output logic             is_last
);
    typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

    localparam logic [IDX_W-1:0] WIDE_LAST   = IDX_W'(WIDE_PIX - 1);
    localparam logic [IDX_W-1:0] NARROW_LAST = IDX_W'(NARROW_PIX - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] last_idx;

    assign req     = (state == ST_RUN);
    assign is_last = req && (idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            last_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    state    <= ST_RUN;
                    idx      <= '0;
                    last_idx <= narrow ? NARROW_LAST : WIDE_LAST;
                end
                ST_RUN: begin
                    if (is_last) state <= ST_IDLE;
                    else         idx   <= idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (req && !is_last) |=> req); // R3
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (req && $past(req)) |-> (idx == IDX_W'($past(idx) + 1'b1))); // R3
endmodule

// File: rtl/cap_addr_gen.sv
module cap_addr_gen #(
    parameter int ADDR_W = 18,
    parameter int OFS_W  = 2,
    parameter int LINE_W = 8,
    parameter int IDX_W  = 8,
    parameter int SHIFT_OFS = 15
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [LINE_W-1:0] line,
    input  logic              half_stride,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base, row, col;

    always_comb begin
        base = ADDR_W'(ofs) << SHIFT_OFS;
        row  = half_stride ? (ADDR_W'(line) << 8) : (ADDR_W'(line) << 9);
        col  = ADDR_W'(idx) << 1;
        addr = base + row + col;
    end
endmodule

// File: rtl/cap_blend.sv
module cap_blend
    import capture_pkg::*;
(
    input  src_sel_e    sel,
    input  logic        a_3d,
    input  logic [4:0]  eva,
    input  logic [4:0]  evb,
    input  pixel_t      scr,
    input  pixel_t      td,
    input  pixel_t      bpix,
    output pixel_t      out
);
    pixel_t     a;
    logic [4:0] ea, eb;
    logic       use_a;

    always_comb begin
        a     = a_3d ? td : scr;
        ea    = ev_limit(eva);
        eb    = ev_limit(evb);
        use_a = (ea != 5'd0) && (!a_3d || a.opaque);
        case (sel)
            SRC_A:   out = a;
            SRC_B:   out = bpix;
            default: begin
                out.opaque = 1'b0;
                out.red    = mix_chan(a.red,   bpix.red,   ea, eb, use_a);
                out.green  = mix_chan(a.green, bpix.green, ea, eb, use_a);
                out.blue   = mix_chan(a.blue,  bpix.blue,  ea, eb, use_a);
            end
        endcase
    end

    AST_MIX_CLEAR_TOP: assert final (!(sel[1] && out.opaque)); // R8
endmodule

// File: rtl/scanline_capture.sv
module scanline_capture
    import capture_pkg::*;
#(
    parameter int LINE_W     = DEF_LINE_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int BANK_W     = DEF_BANK_W,
    parameter int OFS_W      = DEF_OFS_W,
    parameter int EV_W       = DEF_EV_W,
    parameter int WIDE_PIX   = DEF_WIDE_PIX,
    parameter int NARROW_PIX = DEF_NARROW_PIX,
    parameter int LAST_LINE  = DEF_LAST_LINE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_src,
    input  logic              cfg_a_3d,
    input  logic              cfg_narrow,
    input  logic [LINE_W-1:0] cfg_height,
    input  logic [EV_W-1:0]   cfg_eva,
    input  logic [EV_W-1:0]   cfg_evb,
    input  logic [BANK_W-1:0] cfg_wr_bank,
    input  logic [OFS_W-1:0]  cfg_wr_ofs,
    input  logic [BANK_W-1:0] cfg_rd_bank,
    input  logic [OFS_W-1:0]  cfg_rd_ofs,
    input  logic [(1<<BANK_W)-1:0] bank_lcd,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic [15:0]       scr_pix,
    input  logic [15:0]       td_pix,
    output logic              pix_req,
    output logic [$clog2(WIDE_PIX)-1:0] pix_idx,
    output logic [BANK_W-1:0] rd_bank,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       rd_data,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic              line_done,
    output logic              seq_done
);
    localparam int IDX_W = $clog2(WIDE_PIX);

    typedef struct packed {
        src_sel_e          sel;
        logic              a_3d;
        logic              narrow;
        logic [EV_W-1:0]   eva;
        logic [EV_W-1:0]   evb;
        logic [BANK_W-1:0] wbank;
        logic [OFS_W-1:0]  wofs;
        logic [BANK_W-1:0] rbank;
        logic [OFS_W-1:0]  rofs;
        logic [LINE_W-1:0] line;
        logic              dst_ok;
        logic              src_ok;
    } line_cfg_t;

    line_cfg_t         lc;
    logic              go, busy, is_last;
    logic              p1_v, p1_last;
    logic [IDX_W-1:0]  p1_idx;
    logic [ADDR_W-1:0] wr_addr_c;
    pixel_t            b_word, mixed;

    assign busy = pix_req | p1_v;
    assign go   = line_start && cfg_enable && (line_num < cfg_height) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            lc <= '0;
        end else if (go) begin
            lc.sel    <= src_sel_e'(cfg_src);
            lc.a_3d   <= cfg_a_3d;
            lc.narrow <= cfg_narrow;
            lc.eva    <= cfg_eva;
            lc.evb    <= cfg_evb;
            lc.wbank  <= cfg_wr_bank;
            lc.wofs   <= cfg_wr_ofs;
            lc.rbank  <= cfg_rd_bank;
            lc.rofs   <= cfg_rd_ofs;
            lc.line   <= line_num;
            lc.dst_ok <= bank_lcd[cfg_wr_bank];
            lc.src_ok <= bank_lcd[cfg_rd_bank];
        end
    end

    cap_sequencer #(.IDX_W(IDX_W), .WIDE_PIX(WIDE_PIX), .NARROW_PIX(NARROW_PIX)) u_seq (
        .clk(clk), .rst(rst), .go(go), .narrow(cfg_narrow),
        .req(pix_req), .idx(pix_idx), .is_last(is_last)
    );

    cap_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LINE_W(LINE_W), .IDX_W(IDX_W),
                   .SHIFT_OFS(OFS_SHIFT)) u_rd_addr (
        .ofs(lc.rofs), .line(lc.line), .half_stride(1'b0), .idx(pix_idx), .addr(rd_addr)
    );

    cap_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LINE_W(LINE_W), .IDX_W(IDX_W),
                   .SHIFT_OFS(OFS_SHIFT)) u_wr_addr (
        .ofs(lc.wofs), .line(lc.line), .half_stride(lc.narrow), .idx(p1_idx), .addr(wr_addr_c)
    );

    assign rd_bank = lc.rbank;
    assign b_word  = lc.src_ok ? pixel_t'(rd_data) : pixel_t'('0);

    cap_blend u_blend (
        .sel(lc.sel), .a_3d(lc.a_3d), .eva(lc.eva[4:0]), .evb(lc.evb[4:0]),
        .scr(pixel_t'(scr_pix)), .td(pixel_t'(td_pix)), .bpix(b_word), .out(mixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            p1_v      <= 1'b0;
            p1_last   <= 1'b0;
            p1_idx    <= '0;
            wr_en     <= 1'b0;
            wr_bank   <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
            line_done <= 1'b0;
            seq_done  <= 1'b0;
        end else begin
            p1_v      <= pix_req;
            p1_last   <= is_last;
            p1_idx    <= pix_idx;
            wr_en     <= p1_v && lc.dst_ok;
            wr_bank   <= lc.wbank;
            wr_addr   <= wr_addr_c;
            wr_data   <= mixed;
            line_done <= p1_last;
            seq_done  <= line_start && cfg_enable && (line_num == LINE_W'(LAST_LINE));
        end
    end

    AST_MIX_NO_ALPHA: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lc.sel[1]) |-> !wr_data[15]); // R8
    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 2))); // R4
    AST_NO_WR_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> lc.dst_ok); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !line_done); // R14
    AST_SEQ_LINE: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> ($past(line_num) == LINE_W'(LAST_LINE))); // R13
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(lc)); // R12
endmodule

// File: tb/scanline_capture_test.sv
`timescale 1ns/1ps
module scanline_capture_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic [1:0]  cfg_src = 2'b00;
    logic        cfg_a_3d = 1'b0, cfg_narrow = 1'b0;
    logic [7:0]  cfg_height = 8'd192;
    logic [4:0]  cfg_eva = 5'd0, cfg_evb = 5'd0;
    logic [1:0]  cfg_wr_bank = 2'd0, cfg_wr_ofs = 2'd0, cfg_rd_bank = 2'd1, cfg_rd_ofs = 2'd0;
    logic [3:0]  bank_lcd = 4'hF;
    logic        line_start = 1'b0;
    logic [7:0]  line_num = 8'd0;
    logic [15:0] scr_pix = '0, td_pix = '0, rd_data = '0;
    logic        pix_req, wr_en, line_done, seq_done;
    logic [7:0]  pix_idx;
    logic [1:0]  rd_bank, wr_bank;
    logic [17:0] rd_addr, wr_addr;
    logic [15:0] wr_data;

    int checks = 0, errors = 0, done_seen = 0, seq_seen = 0;
    bit finished = 0;
    string cur_tag = "R3";
    logic [35:0] exp_q[$];

    always #2.5 clk = ~clk;

    scanline_capture uut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_src(cfg_src), .cfg_a_3d(cfg_a_3d),
        .cfg_narrow(cfg_narrow), .cfg_height(cfg_height), .cfg_eva(cfg_eva), .cfg_evb(cfg_evb),
        .cfg_wr_bank(cfg_wr_bank), .cfg_wr_ofs(cfg_wr_ofs), .cfg_rd_bank(cfg_rd_bank),
        .cfg_rd_ofs(cfg_rd_ofs), .bank_lcd(bank_lcd), .line_start(line_start), .line_num(line_num),
        .scr_pix(scr_pix), .td_pix(td_pix), .pix_req(pix_req), .pix_idx(pix_idx),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
        .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data), .line_done(line_done),
        .seq_done(seq_done)
    );

    function automatic logic [15:0] scr_fn(input int i);
        return 16'(i * 16'h0123 + 16'h8a51);
    endfunction
    function automatic logic [15:0] td_fn(input int i);
        return 16'((i * 16'h0b37) ^ 16'h4c2d);
    endfunction
    function automatic logic [15:0] mem_fn(input logic [1:0] bk, input logic [17:0] ad);
        return 16'(ad * 7 + (ad >> 5)) ^ {bk, 14'h0a5a};
    endfunction

    // Source models: everything requested is presented one cycle later (R5)
    always @(posedge clk) begin
        if (pix_req) begin
            scr_pix <= scr_fn(int'(pix_idx));
            td_pix  <= td_fn(int'(pix_idx));
            rd_data <= mem_fn(rd_bank, rd_addr);
        end
    end

    function automatic logic [15:0] exp_word(input int line, input int i);
        logic [15:0] a, b, r;
        logic [17:0] ra;
        int ea, eb, s;
        bit use_a;
        a  = cfg_a_3d ? td_fn(i) : scr_fn(i);
        ra = 18'(cfg_rd_ofs * 32768 + line * 512 + 2 * i);
        b  = bank_lcd[cfg_rd_bank] ? mem_fn(cfg_rd_bank, ra) : 16'h0;
        if (cfg_src == 2'b00) return a;
        if (cfg_src == 2'b01) return b;
        ea = (cfg_eva > 16) ? 16 : int'(cfg_eva);
        eb = (cfg_evb > 16) ? 16 : int'(cfg_evb);
        use_a = (ea != 0) && (!cfg_a_3d || a[15]);
        r = '0;
        for (int c = 0; c < 3; c++) begin
            s = (use_a ? int'(a[5*c +: 5]) * ea : 0) + int'(b[5*c +: 5]) * eb;
            s = s >> 4;
            if (s > 31) s = 31;
            r[5*c +: 5] = 5'(s);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expectations as writes appear
    always @(negedge clk) begin
        if (!rst) begin
            if (line_done) done_seen++;
            if (seq_done) seq_seen++;
            if (wr_en) begin
                if (exp_q.size() == 0) begin
                    check(0, cur_tag, "unexpected write addr", 64'(wr_addr), 64'(0));
                end else begin
                    logic [35:0] e;
                    e = exp_q.pop_front();
                    check({wr_bank, wr_addr, wr_data} == e, cur_tag, "bank/addr/data",
                          64'({wr_bank, wr_addr, wr_data}), 64'(e));
                end
            end
        end
    end

    task automatic run_line(input int line, input bit expect_run, input bit disturb, input string tag);
        int width;
        logic [1:0] s_src; logic [4:0] s_eva; logic s_nar; logic [1:0] s_wofs; logic [3:0] s_map;
        cur_tag = tag;
        width = cfg_narrow ? 128 : 256;
        if (expect_run && bank_lcd[cfg_wr_bank]) begin
            for (int i = 0; i < width; i++) begin
                logic [17:0] wa;
                wa = 18'(cfg_wr_ofs * 32768 + line * (cfg_narrow ? 256 : 512) + 2 * i);
                exp_q.push_back({cfg_wr_bank, wa, exp_word(line, i)});
            end
        end
        done_seen = 0;
        @(negedge clk);
        line_num = 8'(line); line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        if (disturb) begin
            repeat (20) @(negedge clk);
            s_src = cfg_src; s_eva = cfg_eva; s_nar = cfg_narrow; s_wofs = cfg_wr_ofs; s_map = bank_lcd;
            cfg_src = 2'b00; cfg_eva = 5'd1; cfg_narrow = ~cfg_narrow; cfg_wr_ofs = 2'd3; bank_lcd = 4'h0;
            line_num = 8'd3; line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
        end
        repeat (300) @(negedge clk);
        check(exp_q.size() == 0, tag, "missing writes", 64'(exp_q.size()), 64'(0));
        exp_q.delete();
        check(done_seen == (expect_run ? 1 : 0), tag, "line_done count (R14)",
              64'(done_seen), 64'(expect_run ? 1 : 0));
        if (disturb) begin
            cfg_src = s_src; cfg_eva = s_eva; cfg_narrow = s_nar; cfg_wr_ofs = s_wofs; bank_lcd = s_map;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check({wr_en, line_done, pix_req, seq_done} == 4'b0, "R1", "outputs in reset",
              64'({wr_en, line_done, pix_req, seq_done}), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        check({wr_en, line_done, pix_req, seq_done} == 4'b0, "R1", "outputs after reset",
              64'({wr_en, line_done, pix_req, seq_done}), 64'(0));
        cfg_enable = 1'b1;

        // R6 R3 R4: copy screen, wide
        cfg_src = 2'b00; cfg_a_3d = 0; cfg_narrow = 0; cfg_wr_ofs = 2'd1;
        run_line(5, 1, 0, "R6");
        // R6 R4: copy 3D, narrow stride
        cfg_a_3d = 1; cfg_narrow = 1; cfg_wr_bank = 2'd2; cfg_wr_ofs = 2'd2;
        run_line(190, 1, 0, "R4");
        // R7 R5: copy B with offsets
        cfg_src = 2'b01; cfg_narrow = 0; cfg_rd_bank = 2'd1; cfg_rd_ofs = 2'd1; cfg_wr_bank = 2'd3;
        run_line(10, 1, 0, "R7");
        // R8 R9: mix with screen A
        cfg_src = 2'b10; cfg_a_3d = 0; cfg_eva = 5'd8; cfg_evb = 5'd8;
        run_line(20, 1, 0, "R8");
        // R9: mix with 3D A, alpha gating
        cfg_src = 2'b11; cfg_a_3d = 1; cfg_eva = 5'd16; cfg_evb = 5'd0;
        run_line(21, 1, 0, "R9");
        // R8: weights above 16 and saturation
        cfg_a_3d = 0; cfg_eva = 5'd20; cfg_evb = 5'd31;
        run_line(22, 1, 0, "R8");
        // R9: zero A weight ignores A
        cfg_eva = 5'd0; cfg_evb = 5'd4;
        run_line(23, 1, 0, "R9");
        // R2: line at height, and capture disabled
        cfg_height = 8'd100;
        run_line(100, 0, 0, "R2");
        cfg_height = 8'd192; cfg_enable = 0;
        run_line(30, 0, 0, "R2");
        cfg_enable = 1;
        // R10: destination unmapped
        bank_lcd = 4'b0111; cfg_wr_bank = 2'd3;
        run_line(31, 1, 0, "R10");
        // R11: source unmapped, copy B and mix
        bank_lcd = 4'b1101; cfg_rd_bank = 2'd1; cfg_wr_bank = 2'd0; cfg_src = 2'b01;
        run_line(32, 1, 0, "R11");
        cfg_src = 2'b10; cfg_eva = 5'd9; cfg_evb = 5'd7;
        run_line(33, 1, 0, "R11");
        bank_lcd = 4'hF;
        // R12: mid-line changes and extra line_start ignored
        cfg_src = 2'b10; cfg_eva = 5'd5; cfg_evb = 5'd11; cfg_narrow = 0; cfg_wr_ofs = 2'd0;
        run_line(40, 1, 1, "R12");
        // R13: final line raises seq_done once
        check(seq_seen == 0, "R13", "seq_done before final line", 64'(seq_seen), 64'(0));
        cfg_src = 2'b00;
        run_line(191, 1, 0, "R13");
        check(seq_seen == 1, "R13", "seq_done count", 64'(seq_seen), 64'(1));

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule